// File: doc/BRIEF.md
# GF(2^m) Message Permutation Unit

This block reorders a probability mass function (PMF) that travels along one edge of a non-binary LDPC Tanner graph. The PMF has one fixed-point probability for each element of GF(2^m). The nonzero parity-check coefficient `h` of that edge says where each entry goes. The block moves the entries to new indices by multiplying each index by `h` in the field. It never does arithmetic on the probabilities themselves.

A job starts with a one-cycle `start` pulse. That pulse captures the whole input vector into a temporary buffer, together with the coefficient and a direction bit. This capture is the read phase. In the write phase that follows, one output entry is written per cycle. In forward mode (`inverse` = 0) the block serves variable-to-check traffic. In inverse mode (`inverse` = 1) it applies the exact inverse mapping to check-to-variable traffic.

Field elements use the polynomial basis: bit i of an index or of the coefficient is the coefficient of α^i. The field is built from the primitive polynomial x^m+x+1, which is x²+x+1, x³+x+1 or x⁴+x+1 for m = 2, 3, 4. Entry i of `din` and `dout` occupies bits [i·W +: W]. Each entry is 8-bit two's complement with one integer bit by default.

Top module: `gf_pmf_perm`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every entry of `dout` is 0.
- R2: A `start` pulse while idle captures `din`, `coef` and `inverse`, and `busy` is 1 in the following cycle. Changes on `din`, `coef` and `inverse` after that capture do not affect the job.
- R3: In forward mode, when the job completes, `dout` entry `h·x` equals the captured `din` entry `x` for every x. The product is taken in GF(2^m), using the polynomial basis and the primitive polynomial x^m+x+1.
- R4: In inverse mode, when the job completes, `dout` entry `x` equals the captured `din` entry `h·x` for every x.
- R5: An inverse-mode job with coefficient h, run on the output of a forward-mode job with the same h, returns the original vector.
- R6: Entry 0 always passes to output entry 0, whatever the coefficient and mode.
- R7: `done` is high for exactly one cycle. It is first observed 2^m+1 cycles after the cycle in which `start` was sampled. `busy` falls in the cycle after `done`.
- R8: A `start` pulse while `busy` is 1 is ignored. The running job's result is unchanged and only one `done` pulse occurs.
- R9: `dout` changes only during a write phase. Between jobs it holds its value, whatever happens on `din`.
- R10: A coefficient of 0 is treated as 1, so the vector passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a job |
| inverse | input | 1 | 0 = forward permutation, 1 = inverse permutation |
| coef | input | M | Edge coefficient h, polynomial basis |
| din | input | 2^M·W | Input PMF, entry i at bits [i·W +: W] |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse after the last write of a job |
| dout | output | 2^M·W | Reordered PMF, entry i at bits [i·W +: W] |

## Verification
The bench sweeps GF(8) exhaustively: every coefficient, both directions and several data patterns. Expected positions come from a power/log table of α that the bench builds itself. A wrong reduction polynomial or a swapped source/destination index would scramble entries at nonzero indices; a round trip through both modes catches a non-inverse mapping. It also pulses `start` in the middle of a job, which a design that re-arms would answer with a different coefficient or a second `done`. It changes `din` after capture and between jobs to expose a missing buffer or a leaky output register. Coefficient zero and a latency count against 2^m+1 cover the remaining edges.

// File: rtl/gf_pmf_perm.sv
module gf_pmf_perm #(
  parameter int M = 3,
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             inverse,
  input  logic [M-1:0]     coef,
  input  logic [(1<<M)*W-1:0] din,
  output logic             busy,
  output logic             done,
  output logic [(1<<M)*W-1:0] dout
);
  localparam int Q = 1 << M;
  localparam logic [M-1:0] RED = M'(3);
  localparam logic [M-1:0] LAST = M'(Q - 1);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_FIN} state_t;

  state_t         state;
  logic [M-1:0]   cnt;
  logic [M-1:0]   h_q;
  logic           inv_q;
  logic [W-1:0]   tmp [Q];
  logic [W-1:0]   dq  [Q];
  logic [M-1:0]   prod, src, dst;

  function automatic logic [M-1:0] gf_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] p, t;
    p = '0;
    t = a;
    for (int i = 0; i < M; i++) begin
      if (b[i]) p = p ^ t;
      t = t[M-1] ? ((t << 1) ^ RED) : (t << 1);
    end
    return p;
  endfunction

  assign prod = gf_mul(h_q, cnt);
  assign src  = inv_q ? prod : cnt;
  assign dst  = inv_q ? cnt : prod;
  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      h_q   <= M'(1);
      inv_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_WR;
          cnt   <= '0;
          h_q   <= (coef == '0) ? M'(1) : coef;
          inv_q <= inverse;
        end
        S_WR: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < Q; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tmp[g] <= '0;
          dq[g]  <= '0;
        end else begin
          if (state == S_IDLE && start) tmp[g] <= din[g*W +: W];
          if (state == S_WR && dst == M'(g)) dq[g] <= tmp[src];
        end
      end
      assign dout[g*W +: W] = dq[g];
    end
  endgenerate

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR && start) |=> ($stable(h_q) && $stable(inv_q))); // R8
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_WR) |=> $stable(dout)); // R9
  AST_ZERO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dout[W-1:0] == tmp[0])); // R6
  AST_COEF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (h_q != '0)); // R10
endmodule

// File: tb/test_gf_pmf_perm.sv
module test_gf_pmf_perm;
  localparam int M = 3;
  localparam int W = 8;
  localparam int Q = 1 << M;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic inverse = 1'b0;
  logic [M-1:0] coef = '0;
  logic [Q*W-1:0] din = '0;
  logic busy, done;
  logic [Q*W-1:0] dout;

  int checks = 0;
  int failures = 0;
  int pw [Q];
  int lg [Q];

  gf_pmf_perm #(.M(M), .W(W)) i_gf_pmf_perm (
    .clk(clk), .rst_n(rst_n), .start(start), .inverse(inverse),
    .coef(coef), .din(din), .busy(busy), .done(done), .dout(dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  task automatic check(input string req, input logic [Q*W-1:0] act, input logic [Q*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int gmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return pw[(lg[a] + lg[b]) % (Q - 1)];
  endfunction

  function automatic logic [Q*W-1:0] model(input logic [Q*W-1:0] v, input int h, input bit inv);
    logic [Q*W-1:0] r = '0;
    int hh = (h == 0) ? 1 : h;
    for (int x = 0; x < Q; x++) begin
      if (inv) r[x*W +: W] = v[gmul(hh, x)*W +: W];
      else     r[gmul(hh, x)*W +: W] = v[x*W +: W];
    end
    return r;
  endfunction

  function automatic logic [Q*W-1:0] pattern(input int seed);
    logic [Q*W-1:0] r;
    for (int i = 0; i < Q; i++) r[i*W +: W] = W'(seed * 37 + i * 11 + 5 + i * i * seed);
    return r;
  endfunction

  task automatic run_job(input int h, input bit inv, input logic [Q*W-1:0] v,
                         input bit poke_busy, output logic [Q*W-1:0] res);
    int lat = 1;
    int dones = 0;
    @(negedge clk);
    coef = M'(h); inverse = inv; din = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    din = ~v; coef = M'(h + 1); inverse = ~inv;
    checks++;
    if (busy !== 1'b1) begin failures++; $display("FAIL R2 busy=%b expected=1", busy); end
    while (done !== 1'b1 && lat < 100) begin
      if (poke_busy && lat == 3) begin
        start = 1'b1; din = pattern(99); coef = M'(h + 3);
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    checks++;
    if (lat != Q + 1) begin failures++; $display("FAIL R7 latency=%0d expected=%0d", lat, Q + 1); end
    res = dout;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done === 1'b1) dones++;
      if (k == 0) begin
        checks++;
        if (busy !== 1'b0) begin failures++; $display("FAIL R7 busy=%b expected=0", busy); end
      end
    end
    checks++;
    if (dones != 0) begin failures++; $display("FAIL R8 extra_done=%0d expected=0", dones); end
  endtask

  initial begin
    logic [Q*W-1:0] r1, r2, v, held;
    pw[0] = 1;
    for (int k = 1; k < Q; k++) begin
      pw[k] = pw[k-1] << 1;
      if (pw[k] >= Q) pw[k] = (pw[k] ^ Q) ^ 3;
    end
    lg[0] = 0;
    for (int k = 0; k < Q - 1; k++) lg[pw[k]] = k;

    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 1'b0 || done !== 1'b0) begin
      failures++; $display("FAIL R1 busy=%b done=%b expected=0 0", busy, done);
    end
    check("R1 dout reset", dout, '0);
    rst_n = 1'b1;

    for (int h = 1; h < Q; h++) begin
      for (int s = 0; s < 3; s++) begin
        v = pattern(h * 3 + s);
        run_job(h, 1'b0, v, 1'b0, r1);
        check("R3 forward", r1, model(v, h, 1'b0));
        checks++;
        if (r1[W-1:0] !== v[W-1:0]) begin
          failures++; $display("FAIL R6 entry0=%h expected=%h", r1[W-1:0], v[W-1:0]);
        end
        run_job(h, 1'b1, v, 1'b0, r2);
        check("R4 inverse", r2, model(v, h, 1'b1));
        run_job(h, 1'b1, r1, 1'b0, r2);
        check("R5 round trip", r2, v);
      end
    end

    v = pattern(50);
    run_job(0, 1'b0, v, 1'b0, r1);
    check("R10 zero coef forward", r1, v);
    run_job(0, 1'b1, v, 1'b0, r1);
    check("R10 zero coef inverse", r1, v);

    v = pattern(61);
    run_job(5, 1'b0, v, 1'b1, r1);
    check("R8 start while busy", r1, model(v, 5, 1'b0));

    held = dout;
    din = pattern(77); coef = 3'd6; inverse = 1'b1;
    repeat (10) @(negedge clk);
    check("R9 hold between jobs", dout, held);

    v = pattern(88);
    run_job(7, 1'b1, v, 1'b0, r1);
    check("R2 capture then R4", r1, model(v, 7, 1'b1));

    finish_run();
  end
endmodule